// File: doc/BRIEF.md
# Two-Wire Register Slave with Access Freeze

This block is a two-wire serial slave that gives a bus host read and write access to a small bank of byte-wide registers. It watches the clock and data lines, detects start and stop conditions, compares the first byte of each transfer against its own 7-bit address, and acknowledges every byte it accepts. A write transfer carries a register index followed by any number of data bytes. A read transfer is normally preceded by a write of the index and a repeated start. The register index steps forward by one after each data byte, whether the byte is written or read, and wraps from the last register back to the first.

While a host access is in progress, the block asserts a hold output that freezes the time counters elsewhere in the chip, so that a multi-byte read or write sees one consistent snapshot. Once-per-second ticks that arrive during the hold are not passed on. Instead they are remembered as a single pending tick, which is issued on the cycle after the hold drops. A watchdog bounds the hold. If an access stays open for longer than the programmed window (one second of system clock), the hold is dropped even though no stop has been seen.

The serial clock is an input only. The data line is modelled as a sampled input plus an output enable that pulls the line low. Clock stretching and multi-master arbitration are not supported.

Top module: `rtc_i2c_regslave`

## Requirements
- R1: The slave acknowledges a first byte of 0xA2 (address 7'h51, bit 0 = 0 for a write) or 0xA3 (bit 0 = 1 for a read). Any other address byte gets no acknowledge, and the bytes that follow it up to the next start or stop are not acknowledged and change no register.
- R2: In a write transfer, the byte after the address sets the register index. Each later byte is stored at the current index and acknowledged, and the index then advances by one.
- R3: In a read transfer, the slave sends the register at the current index, most significant bit first, and advances the index after each byte. It continues while the host acknowledges and stops driving after a host NACK. A read that follows a completed read continues from the advanced index.
- R4: Only the low 4 bits of the index byte are used. The index wraps from 0x0F to 0x00 on both writes and reads.
- R5: The slave pulls the data line low only while the serial clock is low or during its own acknowledge clock. In the acknowledge clock that follows a byte it has sent, it releases the line.
- R6: Hold rises on a start condition and falls on the stop condition that ends the access.
- R7: A tick input that arrives while hold is low appears on the tick output one clock later. Ticks that arrive while hold is high are suppressed, and any number of them produce exactly one tick output on the clock after hold falls.
- R8: If hold stays high for WDOG_CYCLES clocks, the watchdog drops it without waiting for a stop, and any pending tick is issued.
- R9: After reset, all registers read 0x00, the index is 0x00, and hold, tick output and data-line enable are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls the data line low |
| tick_i | input | 1 | One-cycle seconds tick from the prescaler |
| tick_o | output | 1 | Tick passed on to the time counters |
| hold_o | output | 1 | Freeze request to the time counters |

## Verification
The bench writes a burst of bytes that crosses register 0x0F. A pointer that failed to wrap, or that used the upper index bits, would put the third byte in the wrong register, and the burst read-back would expose it. The bench sends a foreign address followed by data bytes. A slave that matched loosely would acknowledge these bytes or overwrite register 3. It pulses two ticks inside an access and checks that exactly one tick comes out after the stop. Losing pending ticks, or passing them through, would change that count. It then leaves an access open past the watchdog window. A design without the timeout would keep hold high and keep the tick back.

// File: rtl/rtc_i2c_pkg.sv
// Package: shared types for the two-wire register slave.
// Assumes nothing beyond IEEE 1800-2017; holds the protocol state encoding.
package rtc_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, ignoring bus until start
        ST_ADDR,   // receiving address byte
        ST_PTR,    // receiving register index byte
        ST_WDATA,  // receiving write data bytes
        ST_ACK,    // slave driving acknowledge
        ST_RDATA,  // slave sending a data byte
        ST_RACK    // host acknowledge clock after a sent byte
    } bus_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: synchronises the two bus lines into the system clock domain and
// flags clock edges and start/stop conditions.
// Assumes the system clock is many times faster than the serial clock.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] scl_q;
    logic [1:0] sda_q;
    logic       scl_d;
    logic       sda_d;

    // Two-stage synchroniser plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 2'b11;
            sda_q <= 2'b11;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[0], scl_i};
            sda_q <= {sda_q[0], sda_i};
            scl_d <= scl_q[1];
            sda_d <= sda_q[1];
        end
    end

    // Edge and condition decode from current and previous samples.
    always_comb begin
        scl_lvl   = scl_q[1];
        sda_lvl   = sda_q[1];
        scl_rise  = scl_q[1] & ~scl_d;
        scl_fall  = ~scl_q[1] & scl_d;
        start_det = scl_q[1] & scl_d & sda_d & ~sda_q[1];
        stop_det  = scl_q[1] & scl_d & ~sda_d & sda_q[1];
    end

endmodule

// File: rtl/i2c_reg_engine.sv
// Module: byte-level protocol engine. Matches the slave address, captures the
// register index, writes or reads bytes with acknowledge, auto-advances the
// index with wrap. Assumes edge/condition strobes from i2c_line_sync.
module i2c_reg_engine
    import rtc_i2c_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter int          ADDR_W     = 4,
    parameter logic [6:0]  SLAVE_ADDR = 7'h51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int                CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  BITS  = CNT_W'(DATA_W);

    bus_state_t        state;
    bus_state_t        resume_st;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              host_ack;

    // Protocol sequencer: shifts bits on clock rise, drives line on clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            resume_st <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            sda_oe    <= 1'b0;
            ptr       <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            host_ack  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise && cnt < BITS) begin
                            shreg <= {shreg[DATA_W-2:0], sda_lvl};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == BITS) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[DATA_W-1:1] == SLAVE_ADDR) begin
                                    sda_oe    <= 1'b1;
                                    state     <= ST_ACK;
                                    resume_st <= shreg[0] ? ST_RDATA : ST_PTR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_PTR) begin
                                ptr       <= shreg[ADDR_W-1:0];
                                sda_oe    <= 1'b1;
                                state     <= ST_ACK;
                                resume_st <= ST_WDATA;
                            end else begin
                                wr_en     <= 1'b1;
                                wr_addr   <= ptr;
                                wr_data   <= shreg;
                                ptr       <= ptr + 1'b1;
                                sda_oe    <= 1'b1;
                                state     <= ST_ACK;
                                resume_st <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (resume_st == ST_RDATA) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[DATA_W-1];
                                ptr    <= ptr + 1'b1;
                                cnt    <= '0;
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= resume_st;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == BITS) begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                state  <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                                sda_oe <= ~shreg[DATA_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[DATA_W-1];
                                ptr    <= ptr + 1'b1;
                                cnt    <= '0;
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    // R5: the line is only ever newly pulled low while the clock is low.
    a_r5_oe_rise_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R5: no drive during the host acknowledge clock.
    a_r5_release_host_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK) |-> !sda_oe);

    // R4: a write at the last index leaves the pointer at zero.
    a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '1) |-> (ptr == '0));

    // R2: stores happen only while acknowledging a byte.
    a_r2_write_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_ACK));

endmodule

// File: rtl/rtc_access_freeze.sv
// Module: holds the time counters during a bus access, collects ticks that
// arrive meanwhile into one pending tick, and bounds the hold with a watchdog.
// Assumes tick_i is a one-cycle pulse.
module rtc_access_freeze #(
    parameter int WDOG_CYCLES = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic stop_det,
    input  logic tick_i,
    output logic hold_o,
    output logic tick_o
);

    localparam int WD_W = $clog2(WDOG_CYCLES + 1);
    localparam logic [WD_W-1:0] WD_LAST = WD_W'(WDOG_CYCLES - 1);

    logic [WD_W-1:0] wd_cnt;
    logic            pend;
    logic            expire;
    logic            release_now;

    // Release decode: stop or watchdog expiry while held.
    always_comb begin
        expire      = hold_o && (wd_cnt == WD_LAST);
        release_now = hold_o && (stop_det || expire);
    end

    // Hold flag, watchdog counter, pending tick and tick forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_o <= 1'b0;
            wd_cnt <= '0;
            pend   <= 1'b0;
            tick_o <= 1'b0;
        end else begin
            if (start_det && !hold_o) begin
                hold_o <= 1'b1;
                wd_cnt <= '0;
            end else if (release_now) begin
                hold_o <= 1'b0;
                wd_cnt <= '0;
            end else if (hold_o) begin
                wd_cnt <= wd_cnt + 1'b1;
            end
            tick_o <= (!hold_o && tick_i) || (release_now && (pend || tick_i));
            pend   <= (hold_o && !release_now) ? (pend | tick_i) : 1'b0;
        end
    end

    // R6: a start from idle raises hold.
    a_r6_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !hold_o) |=> hold_o);

    // R6: a stop drops hold.
    a_r6_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hold_o);

    // R7: no tick leaves while hold has been high for two cycles.
    a_r7_quiet_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && $past(hold_o)) |-> !tick_o);

    // R7: a pending tick is issued on release.
    a_r7_pending_out: assert property (@(posedge clk) disable iff (!rst_n)
        (release_now && pend) |=> tick_o);

    // R8: the watchdog count never passes its window.
    a_r8_wd_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> (wd_cnt <= WD_LAST));

endmodule

// File: rtl/rtc_i2c_regslave.sv
// Module: top of the two-wire register slave. Holds the register bank and
// ties the line synchroniser, protocol engine and access freeze together.
// Assumes scl_i/sda_i are asynchronous to clk; reset is synchronous.
module rtc_i2c_regslave #(
    parameter int         NUM_REGS    = 16,
    parameter int         DATA_W      = 8,
    parameter logic [6:0] SLAVE_ADDR  = 7'h51,
    parameter int         WDOG_CYCLES = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    input  logic tick_i,
    output logic tick_o,
    output logic hold_o
);

    localparam int ADDR_W = $clog2(NUM_REGS);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] regs [NUM_REGS];

    i2c_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_reg_engine #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .SLAVE_ADDR (SLAVE_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    rtc_access_freeze #(
        .WDOG_CYCLES (WDOG_CYCLES)
    ) u_freeze (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .tick_i    (tick_i),
        .hold_o    (hold_o),
        .tick_o    (tick_o)
    );

    // Register bank: cleared on reset, one byte stored per engine write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                regs[i] <= wr_data;
            end
        end
    end

    // Read port: register at the current index.
    always_comb rd_data = regs[ptr];

    // R2: a store lands in the addressed register.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: tb/rtc_i2c_regslave_tb.sv
// Bench: bus-master tasks drive the slave; a vector table of (index, data)
// pairs is written and read back, then directed tests cover reset, bursts with
// wrap, a foreign address, tick freezing and the watchdog.
module rtc_i2c_regslave_tb_top;

    localparam int Q  = 20;
    localparam int WD = 6000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic tick_in = 1'b0;
    logic sda_oe;
    logic tick_out;
    logic hold;
    logic sda_line;

    int checks = 0;
    int fails = 0;
    int tcount = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    rtc_i2c_regslave #(.WDOG_CYCLES(WD)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .tick_i   (tick_in),
        .tick_o   (tick_out),
        .hold_o   (hold)
    );

    always @(posedge clk) if (rst_n && tick_out) tcount <= tcount + 1;

    localparam logic [15:0] VEC [6] = '{16'h035A, 16'h00C3, 16'h0701,
                                        16'h0BFF, 16'h0F80, 16'h093C};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        ack = !sda_line;
        wq(); scl = 1'b0; wq();
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0; wq();
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        wq(); scl = 1'b1; wq();
        chk("R5 release in host ack", int'(sda_oe), 0);
        wq(); scl = 1'b0; wq(); sda_m = 1'b1;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick_in = 1'b1; @(negedge clk); tick_in = 1'b0;
    endtask

    task automatic reg_write1(input logic [7:0] p, input logic [7:0] d);
        bit a;
        bus_start();
        wr_byte(8'hA2, a); chk("R1 write address ack", int'(a), 1);
        wr_byte(p, a);     chk("R5 index ack", int'(a), 1);
        wr_byte(d, a);     chk("R2 data ack", int'(a), 1);
        bus_stop();
    endtask

    task automatic set_ptr_and_read(input logic [7:0] p);
        bit a;
        bus_start();
        wr_byte(8'hA2, a); chk("R1 write address ack", int'(a), 1);
        wr_byte(p, a);     chk("R5 index ack", int'(a), 1);
        bus_start();
        wr_byte(8'hA3, a); chk("R1 read address ack", int'(a), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        bit a;
        int t0;

        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9: outputs after reset.
        chk("R9 hold after reset", int'(hold), 0);
        chk("R9 sda_oe after reset", int'(sda_oe), 0);
        chk("R9 tick_o after reset", int'(tick_out), 0);

        // R9: index 0 and register 0 cleared, read with no index write.
        bus_start();
        wr_byte(8'hA3, a); chk("R1 read address ack", int'(a), 1);
        rd_byte(1'b0, b);  chk("R9 reg0 after reset", int'(b), 0);
        bus_stop();

        // R2/R3: vector table written and read back.
        for (int k = 0; k < 6; k++) begin
            reg_write1(VEC[k][15:8], VEC[k][7:0]);
            set_ptr_and_read(VEC[k][15:8]);
            rd_byte(1'b0, b);
            chk("R3 table read-back", int'(b), int'(VEC[k][7:0]));
            bus_stop();
        end

        // R4: burst write from 0x0E wraps to 0x00.
        bus_start();
        wr_byte(8'hA2, a); chk("R1 write address ack", int'(a), 1);
        wr_byte(8'h0E, a);
        wr_byte(8'h11, a); chk("R2 burst ack", int'(a), 1);
        wr_byte(8'h22, a);
        wr_byte(8'h33, a); chk("R4 ack after wrap", int'(a), 1);
        bus_stop();

        // R3/R4: burst read from 0x0E.
        set_ptr_and_read(8'h0E);
        rd_byte(1'b1, b); chk("R3 burst byte 0", int'(b), 'h11);
        rd_byte(1'b1, b); chk("R4 burst byte 1", int'(b), 'h22);
        rd_byte(1'b0, b); chk("R4 wrapped byte", int'(b), 'h33);
        repeat (10) @(negedge clk);
        chk("R3 released after nack", int'(sda_oe), 0);
        bus_stop();

        // R3: a fresh read continues at index 0x01 (never written).
        bus_start();
        wr_byte(8'hA3, a);
        rd_byte(1'b0, b); chk("R3 continue from index", int'(b), 0);
        bus_stop();

        // R1: foreign address ignored and nothing stored.
        bus_start();
        wr_byte(8'h90, a); chk("R1 foreign address nack", int'(a), 0);
        wr_byte(8'h03, a); chk("R1 foreign index nack", int'(a), 0);
        wr_byte(8'h55, a); chk("R1 foreign data nack", int'(a), 0);
        bus_stop();
        set_ptr_and_read(8'h03);
        rd_byte(1'b0, b); chk("R1 reg3 unchanged", int'(b), 'h5A);
        bus_stop();

        // R4: upper index bits ignored (0x25 selects register 5).
        reg_write1(8'h25, 8'hA7);
        set_ptr_and_read(8'h05);
        rd_byte(1'b0, b); chk("R4 upper index bits", int'(b), 'hA7);
        bus_stop();

        // R7: free-running tick passes with one cycle latency.
        repeat (5) @(negedge clk);
        t0 = tcount;
        pulse_tick();
        chk("R7 tick passes", int'(tick_out), 1);
        repeat (3) @(negedge clk);
        chk("R7 one tick counted", tcount - t0, 1);

        // R6/R7: ticks held during an access, one issued after stop.
        bus_start();
        chk("R6 hold after start", int'(hold), 1);
        wr_byte(8'hA2, a);
        t0 = tcount;
        pulse_tick();
        repeat (40) @(negedge clk);
        pulse_tick();
        repeat (5) @(negedge clk);
        chk("R7 no tick while held", tcount - t0, 0);
        bus_stop();
        repeat (5) @(negedge clk);
        chk("R6 hold after stop", int'(hold), 0);
        chk("R7 one pending tick", tcount - t0, 1);

        // R8: watchdog ends an access left open.
        bus_start();
        wr_byte(8'hA2, a);
        t0 = tcount;
        pulse_tick();
        chk("R8 held before timeout", int'(hold), 1);
        repeat (WD + 100) @(negedge clk);
        chk("R8 hold dropped by watchdog", int'(hold), 0);
        chk("R8 pending tick released", tcount - t0, 1);
        bus_stop();
        repeat (5) @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule